// File: doc/BRIEF.md
# ALU with Selective Condition Flags

This block is the execute-stage arithmetic/logic unit of a small 16-bit processor. Each cycle it takes two operands and a 4-bit operation code. It produces a result at once, with no register in the path. Beside the datapath sits a small registered flag file that holds four condition bits: zero, negative, carry and overflow. When the issue strobe is high, the flag file takes new values at the clock edge.

Each operation class owns a fixed subset of the flags. The block reports that subset as a write mask, and the flag file changes only the masked bits. The rotates and the carry-in add and subtract read the stored carry bit, so a sequence of these operations can chain a multi-word value through the carry. Codes with no operation assigned pass operand a through and leave all flags unchanged.

Top module: `alu_flags_core`

## Requirements
- R1: Codes 0000 (and), 0001 (or), 0110 (xor) and 0111 (not, which inverts a and ignores b) give the bitwise result. They write only zero and negative.
- R2: Code 0010 shifts a left by one and code 0011 shifts a right by one. A zero enters the vacated end. The carry receives the bit shifted out (bit 15 for left, bit 0 for right). Zero, negative and carry are written.
- R3: Code 1010 rotates left with the stored carry entering bit 0. Code 1011 rotates right with the stored carry entering bit 15. Carry receives the bit shifted out. Zero, negative and carry are written.
- R4: Code 0100 returns a+b modulo 2^16. Carry is the unsigned carry out. Overflow is set when a and b share a sign and the result sign differs. All four flags are written.
- R5: Code 0101 returns a−b. Carry is set when a borrow occurs (a < b unsigned). Overflow is set when a and b differ in sign and the result sign differs from a. All four flags are written.
- R6: Code 1100 returns a+b+carry and code 1101 returns a−b−carry, where carry is the stored bit. Carry out and borrow follow R4 and R5. Overflow is not written.
- R7: When written, zero is set exactly when the result is 0x0000, and negative is set to result bit 15.
- R8: Output flag_wr_o gives the flags that the current code writes, using the bit order [0]=zero, [1]=negative, [2]=carry, [3]=overflow: 0011 for the logic ops, 0111 for shifts, rotates, adc and sbc, 1111 for add and sub, and 0000 for unused codes.
- R9: Codes 1000, 1001, 1110 and 1111 return operand a unchanged and leave every flag unchanged.
- R10: Reset clears all flags. Flags change only at a rising clock edge with exec_i high. With exec_i low they hold, whatever the operation code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Issue strobe; commits the masked flags at the clock edge |
| op_i | input | 4 | Operation code |
| a_i | input | 16 | Operand a |
| b_i | input | 16 | Operand b |
| result_o | output | 16 | Combinational result |
| flag_wr_o | output | 4 | Flags written by the current code ([0]=Z [1]=N [2]=C [3]=V) |
| flags_o | output | 4 | Stored flags ([0]=Z [1]=N [2]=C [3]=V) |

## Verification
The directed sequence uses operands that sit at the sign boundary (0x7FFF+1, 0x8000+0x8000, 0x8000−1). These tell signed overflow apart from unsigned carry, and a borrow apart from a sign change. Shift and rotate operands place a single set bit at either edge, which shows whether a zero or the stored carry was shifted in and which bit was shifted out. Because the sequence runs without resets in between, each result shows whether untouched flags keep their earlier values, for example overflow surviving through the adc and sbc steps. Runs with unused codes and with the strobe low check that neither the result nor the flags change where they must not.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int FLAG_W = 4;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_SHL = 4'b0010,
    OP_SHR = 4'b0011,
    OP_ADD = 4'b0100,
    OP_SUB = 4'b0101,
    OP_XOR = 4'b0110,
    OP_NOT = 4'b0111,
    OP_ROL = 4'b1010,
    OP_ROR = 4'b1011,
    OP_ADC = 4'b1100,
    OP_SBC = 4'b1101
  } alu_op_e;

  // packed MSB..LSB => bit3..bit0
  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } flags_t;

  localparam flags_t WR_LOGIC = '{v: 1'b0, c: 1'b0, n: 1'b1, z: 1'b1};
  localparam flags_t WR_SHIFT = '{v: 1'b0, c: 1'b1, n: 1'b1, z: 1'b1};
  localparam flags_t WR_ARITH = '{v: 1'b1, c: 1'b1, n: 1'b1, z: 1'b1};
  localparam flags_t WR_NONE  = '{v: 1'b0, c: 1'b0, n: 1'b0, z: 1'b0};
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        sel_i,   // 00 and, 01 or, 10 xor, 11 not
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      2'b00:   res_o = a_i & b_i;
      2'b01:   res_o = a_i | b_i;
      2'b10:   res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
  parameter int DATA_W = 16
) (
  input  logic              right_i,
  input  logic              rotate_i,
  input  logic              cin_i,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  logic fill;
  assign fill = rotate_i & cin_i;

  always_comb begin
    if (right_i) begin
      res_o  = {fill, a_i[DATA_W-1:1]};
      cout_o = a_i[0];
    end else begin
      res_o  = {a_i[DATA_W-2:0], fill};
      cout_o = a_i[DATA_W-1];
    end
  end
endmodule

// File: rtl/alu_adder_unit.sv
module alu_adder_unit #(
  parameter int DATA_W = 16
) (
  input  logic              sub_i,
  input  logic              use_cin_i,
  input  logic              cin_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,  // carry for add, borrow for sub
  output logic              ovf_o
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] a_ext, b_ext, c_ext, full;

  assign a_ext = {1'b0, a_i};
  assign b_ext = {1'b0, b_i};
  assign c_ext = {{DATA_W{1'b0}}, use_cin_i & cin_i};

  always_comb begin
    if (sub_i) full = a_ext - b_ext - c_ext;
    else       full = a_ext + b_ext + c_ext;
  end

  assign res_o  = full[DATA_W-1:0];
  assign cout_o = full[DATA_W];

  logic sa, sb, sr;
  assign sa = a_i[DATA_W-1];
  assign sb = b_i[DATA_W-1] ^ sub_i;
  assign sr = full[DATA_W-1];
  assign ovf_o = (sa == sb) && (sr != sa);
endmodule

// File: rtl/alu_flag_file.sv
module alu_flag_file
  import alu_flag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  flags_t mask_i,
  input  flags_t next_i,
  output flags_t flags_o
);
  flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= (q & ~mask_i) | (next_i & mask_i);
  end

  assign flags_o = q;

  assert_masked_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((flags_o & ~$past(mask_i)) == ($past(flags_o) & ~$past(mask_i))));
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(flags_o));
endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flag_wr_o,
  output logic [FLAG_W-1:0] flags_o
);
  typedef enum logic [1:0] {CL_LOGIC, CL_SHIFT, CL_ADD, CL_PASS} op_class_e;

  op_class_e cls;
  flags_t    mask, cur, nxt;
  logic [1:0] logic_sel;
  logic       is_sub_add; // plain add/sub writes V

  always_comb begin
    logic_sel  = 2'b00;
    is_sub_add = 1'b0;
    cls        = CL_PASS;
    unique case (op_i)
      OP_AND: begin cls = CL_LOGIC; logic_sel = 2'b00; end
      OP_OR:  begin cls = CL_LOGIC; logic_sel = 2'b01; end
      OP_XOR: begin cls = CL_LOGIC; logic_sel = 2'b10; end
      OP_NOT: begin cls = CL_LOGIC; logic_sel = 2'b11; end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: cls = CL_SHIFT;
      OP_ADD, OP_SUB: begin cls = CL_ADD; is_sub_add = 1'b1; end
      OP_ADC, OP_SBC: cls = CL_ADD;
      default: cls = CL_PASS;
    endcase
  end

  logic [DATA_W-1:0] log_res, sh_res, add_res;
  logic sh_c, add_c, add_v;

  alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .sel_i(logic_sel), .a_i(a_i), .b_i(b_i), .res_o(log_res)
  );

  alu_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .right_i(op_i[0]), .rotate_i(op_i[3]), .cin_i(cur.c),
    .a_i(a_i), .res_o(sh_res), .cout_o(sh_c)
  );

  alu_adder_unit #(.DATA_W(DATA_W)) u_adder (
    .sub_i(op_i[0]), .use_cin_i(op_i[3]), .cin_i(cur.c),
    .a_i(a_i), .b_i(b_i), .res_o(add_res), .cout_o(add_c), .ovf_o(add_v)
  );

  always_comb begin
    unique case (cls)
      CL_LOGIC: begin result_o = log_res; mask = WR_LOGIC; end
      CL_SHIFT: begin result_o = sh_res;  mask = WR_SHIFT; end
      CL_ADD:   begin result_o = add_res; mask = is_sub_add ? WR_ARITH : WR_SHIFT; end
      default:  begin result_o = a_i;     mask = WR_NONE;  end
    endcase
    nxt.z = (result_o == '0);
    nxt.n = result_o[DATA_W-1];
    nxt.c = (cls == CL_SHIFT) ? sh_c : add_c;
    nxt.v = add_v;
  end

  alu_flag_file u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(exec_i),
    .mask_i(mask), .next_i(nxt), .flags_o(cur)
  );

  assign flag_wr_o = mask;
  assign flags_o   = cur;

  assert_zero_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && flag_wr_o[0]) |=> (flags_o[0] == ($past(result_o) == '0)));
  assert_neg_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && flag_wr_o[1]) |=> (flags_o[1] == $past(result_o[DATA_W-1])));
  assert_unused_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && (op_i == 4'b1000 || op_i == 4'b1001 || op_i == 4'b1110 || op_i == 4'b1111))
      |=> $stable(flags_o));
  assert_add_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == OP_ADD && a_i[DATA_W-1] == b_i[DATA_W-1]
      && result_o[DATA_W-1] != a_i[DATA_W-1]) |=> flags_o[3]);
  assert_adc_keeps_v_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && (op_i == OP_ADC || op_i == OP_SBC)) |=> $stable(flags_o[3]));
endmodule

// File: tb/alu_flags_core_tb.sv
module alu_flags_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic [3:0]  op = 4'h0;
  logic [15:0] a = '0, b = '0;
  logic [15:0] result;
  logic [3:0]  flag_wr, flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  alu_flags_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .op_i(op),
    .a_i(a), .b_i(b), .result_o(result), .flag_wr_o(flag_wr), .flags_o(flags)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive at negedge, check combinational outputs, then flags after the edge.
  // Flag nibble is {V,C,N,Z}.
  task automatic run_op(string req, logic en, logic [3:0] o, logic [15:0] va, logic [15:0] vb,
                        logic [15:0] exp_res, logic [3:0] exp_wr, logic [3:0] exp_flags);
    @(negedge clk);
    exec = en; op = o; a = va; b = vb;
    #1;
    chk(req, "result", result, exp_res);
    chk(req, "flag_wr", {12'h0, flag_wr}, {12'h0, exp_wr});
    @(posedge clk); #1;
    chk(req, "flags", {12'h0, flags}, {12'h0, exp_flags});
    exec = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R10", "reset flags", {12'h0, flags}, 16'h0);
  endtask

  task automatic t_add_overflow;
    run_op("R4", 1, 4'b0100, 16'h7FFF, 16'h0001, 16'h8000, 4'b1111, 4'b1010);
  endtask

  task automatic t_logic;
    run_op("R1", 1, 4'b0000, 16'hFF00, 16'h0F0F, 16'h0F00, 4'b0011, 4'b1000);
    run_op("R7", 1, 4'b0001, 16'h0000, 16'h0000, 16'h0000, 4'b0011, 4'b1001);
    run_op("R1", 1, 4'b0110, 16'hA5A5, 16'hFFFF, 16'h5A5A, 4'b0011, 4'b1000);
    run_op("R1", 1, 4'b0111, 16'h00FF, 16'h1234, 16'hFF00, 4'b0011, 4'b1010);
  endtask

  task automatic t_shift_rotate;
    run_op("R2", 1, 4'b0010, 16'h8001, 16'h0000, 16'h0002, 4'b0111, 4'b1100);
    run_op("R3", 1, 4'b1010, 16'h4000, 16'h0000, 16'h8001, 4'b0111, 4'b1010);
    run_op("R3", 1, 4'b1011, 16'h0001, 16'h0000, 16'h0000, 4'b0111, 4'b1101);
    run_op("R3", 1, 4'b1011, 16'h0002, 16'h0000, 16'h8001, 4'b0111, 4'b1010);
    run_op("R2", 1, 4'b0011, 16'h0001, 16'h0000, 16'h0000, 4'b0111, 4'b1101);
  endtask

  task automatic t_sub;
    run_op("R5", 1, 4'b0101, 16'h0003, 16'h0005, 16'hFFFE, 4'b1111, 4'b0110);
    run_op("R5", 1, 4'b0101, 16'h8000, 16'h0001, 16'h7FFF, 4'b1111, 4'b1000);
  endtask

  task automatic t_add_carry;
    run_op("R4", 1, 4'b0100, 16'hFFFF, 16'h0002, 16'h0001, 4'b1111, 4'b0100);
    run_op("R4", 1, 4'b0100, 16'h8000, 16'h8000, 16'h0000, 4'b1111, 4'b1101);
  endtask

  task automatic t_chain;
    run_op("R6", 1, 4'b1100, 16'hFFFF, 16'h0000, 16'h0000, 4'b0111, 4'b1101);
    run_op("R6", 1, 4'b1101, 16'h0005, 16'h0002, 16'h0002, 4'b0111, 4'b1000);
    run_op("R6", 1, 4'b1101, 16'h0000, 16'h0000, 16'h0000, 4'b0111, 4'b1001);
    run_op("R6", 1, 4'b1101, 16'h0000, 16'h0001, 16'hFFFF, 4'b0111, 4'b1110);
    run_op("R6", 1, 4'b1100, 16'h0001, 16'h0001, 16'h0003, 4'b0111, 4'b1000);
  endtask

  task automatic t_unused;
    logic [3:0] codes [4] = '{4'b1000, 4'b1001, 4'b1110, 4'b1111};
    foreach (codes[i])
      run_op("R9", 1, codes[i], 16'h1234, 16'hFFFF, 16'h1234, 4'b0000, 4'b1000);
  endtask

  task automatic t_idle;
    run_op("R10", 0, 4'b0100, 16'h0000, 16'h0000, 16'h0000, 4'b1111, 4'b1000);
    run_op("R10", 0, 4'b0111, 16'h0000, 16'h0000, 16'hFFFF, 4'b0011, 4'b1000);
  endtask

  initial begin
    t_reset();
    repeat (2) @(posedge clk);
    #1;
    chk("R10", "flags held in reset", {12'h0, flags}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    t_add_overflow();
    t_logic();
    t_shift_rotate();
    t_sub();
    t_add_carry();
    t_chain();
    t_unused();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule